// File: doc/BRIEF.md
# Port-Bus Resource Decoder with Aliased Ranges

This block sits on the port bus of a small 8-bit soft processor. It connects three local storage resources to that bus: a 64-word by 8-bit memory, one 8-bit register and a single-bit flag. When the processor writes, the block looks at the upper bits of the port address and passes the data to exactly one resource, and only while the write strobe is high. When the processor reads, the same address bits pick which resource drives the read-data bus.

Only the top address bits are decoded. Each resource therefore answers at every address in its range. The memory uses the low six address bits as its word index. The register appears 64 times and the flag appears 128 times. The read path has one register stage, which fits the processor sampling its input at the end of the second cycle of an input operation. When the flag is read, it is widened to a full byte with zeros in the upper bits.

Top module: `port_space_decoder`

## Requirements
- R1: A synchronous reset clears the register, the flag and the registered read-data output to zero. Memory contents are not reset.
- R2: Addresses with bits [7:6] equal to 00 (0 to 63) select the memory, and address bits [5:0] index the word. A write strobe stores `wr_data` into that word.
- R3: Addresses with bits [7:6] equal to 01 (64 to 127) all select the same 8-bit register. A write strobe at any of these addresses loads `wr_data` into it.
- R4: Addresses with bit 7 equal to 1 (128 to 255) all select the same 1-bit flag. A write strobe at any of these addresses loads bit 0 of `wr_data` into it.
- R5: While `wr_stb` is low, no resource changes, whatever the address and data are.
- R6: A strobed write changes only the resource selected by its address. The other two resources keep their contents.
- R7: `rd_data` is registered. The value present after a rising edge is the content of the resource addressed before that edge, and it holds until the next edge.
- R8: When a flag address is read, `rd_data` bits [7:1] are zero and bit 0 is the flag.
- R9: A read in the same cycle as a write to the same resource returns the content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Port address from the processor |
| wr_data | input | 8 | Data the processor is writing |
| wr_stb | input | 1 | Write strobe, active high, one cycle per write |
| rd_data | output | 8 | Registered read data returned to the processor |

## Verification
The assertions check the following on every cycle:
- a strobed write at any register or flag alias is loaded on the next edge;
- the register and the flag hold whenever they are not written;
- a read of a flag address always has zero upper bits;
- a read of a register address returns the value the register held one cycle earlier.

Some behaviours can only be shown by the bench's scenarios:
- that the whole memory array is indexed correctly;
- that every alias reaches the same storage;
- that writes to one resource leave the others intact;
- the exact cycle in which the read bus changes.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Which local resource an address refers to.
    typedef enum logic [1:0] {
        TGT_MEM  = 2'd0,
        TGT_REG  = 2'd1,
        TGT_FLAG = 2'd2
    } tgt_e;

endpackage

// File: rtl/psd_decode.sv
module psd_decode
    import psd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    output tgt_e              tgt,
    output logic              we_mem,
    output logic              we_reg,
    output logic              we_flag
);

    // Only the two top address bits take part in the decode.
    logic [1:0] top_bits;

    always_comb begin
        top_bits = addr[ADDR_W-1 -: 2];
        if (top_bits[1]) begin
            tgt = TGT_FLAG;
        end else if (top_bits[0]) begin
            tgt = TGT_REG;
        end else begin
            tgt = TGT_MEM;
        end
        we_mem  = wr_stb && (tgt == TGT_MEM);
        we_reg  = wr_stb && (tgt == TGT_REG);
        we_flag = wr_stb && (tgt == TGT_FLAG);
    end

endmodule

// File: rtl/psd_store.sv
module psd_store #(
    parameter int DATA_W = 8,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_mem,
    input  logic              we_reg,
    input  logic              we_flag,
    input  logic [MEM_AW-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] reg_val,
    output logic              flag_val
);

    localparam int DEPTH = 1 << MEM_AW;

    typedef struct packed {
        logic [DATA_W-1:0] reg_v;
        logic              flag_v;
    } state_t;

    state_t st_d, st_q;

    // Memory words, each with its own enable decoded from the index.
    logic [DATA_W-1:0] words_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        always_ff @(posedge clk) begin
            if (we_mem && (widx == MEM_AW'(gi))) begin
                words_q[gi] <= wdata;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (we_reg) begin
            st_d.reg_v = wdata;
        end
        if (we_flag) begin
            st_d.flag_v = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_word = words_q[widx];
    assign reg_val  = st_q.reg_v;
    assign flag_val = st_q.flag_v;

    // R3: a load of the register takes the data on the bus
    a_r3_reg_takes_data: assert property (@(posedge clk) disable iff (rst)
        we_reg |=> reg_val == $past(wdata));

    // R4: a load of the flag keeps bit 0 of the data
    a_r4_flag_takes_bit0: assert property (@(posedge clk) disable iff (rst)
        we_flag |=> flag_val == $past(wdata[0]));

endmodule

// File: rtl/port_space_decoder.sv
module port_space_decoder
    import psd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_stb,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - 1;

    tgt_e              tgt;
    logic              we_mem, we_reg, we_flag;
    logic [DATA_W-1:0] mem_word, reg_val;
    logic              flag_val;

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } rdst_t;

    rdst_t rs_d, rs_q;

    psd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (addr),
        .wr_stb  (wr_stb),
        .tgt     (tgt),
        .we_mem  (we_mem),
        .we_reg  (we_reg),
        .we_flag (we_flag)
    );

    psd_store #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we_mem   (we_mem),
        .we_reg   (we_reg),
        .we_flag  (we_flag),
        .widx     (addr[MEM_AW-1:0]),
        .wdata    (wr_data),
        .mem_word (mem_word),
        .reg_val  (reg_val),
        .flag_val (flag_val)
    );

    // Read multiplexer. It samples the content before this cycle's write.
    always_comb begin
        rs_d = rs_q;
        unique case (tgt)
            TGT_MEM:  rs_d.rd = mem_word;
            TGT_REG:  rs_d.rd = reg_val;
            TGT_FLAG: rs_d.rd = {{PAD_W{1'b0}}, flag_val};
            default:  rs_d.rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rd_data = rs_q.rd;

    // R5 and R6: the register holds unless strobed at one of its aliases
    a_r5_reg_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && addr[ADDR_W-1 -: 2] == 2'b01) |=> $stable(reg_val));

    // R5 and R6: the flag holds unless strobed in the upper half
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && addr[ADDR_W-1]) |=> $stable(flag_val));

    // R8: a flag read has zero upper bits
    a_r8_flag_padded: assert property (@(posedge clk) disable iff (rst)
        addr[ADDR_W-1] |=> rd_data[DATA_W-1:1] == '0);

    // R7 and R9: a register read returns the value from before the edge
    a_r7_reg_read: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1 -: 2] == 2'b01) |=> rd_data == $past(reg_val));

endmodule

// File: tb/port_space_decoder_tb.sv
module port_space_decoder_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr;
    logic [7:0] wr_data;
    logic       wr_stb;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_mem [64];
    logic [7:0] exp_reg;
    logic       exp_flag;

    always #5 clk = ~clk;

    port_space_decoder u_dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_stb  (wr_stb),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: inputs change on the falling edge, output is sampled 1 ns after the rising edge.
    task automatic cycle(input logic [7:0] a, input logic [7:0] d, input logic s);
        @(negedge clk);
        addr    = a;
        wr_data = d;
        wr_stb  = s;
        @(posedge clk);
        #1;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        cycle(a, 8'h00, 1'b0);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = 8'h00; wr_data = 8'h00; wr_stb = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 rd_data after reset", rd_data, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        rd_check("R1 register cleared", 8'd64, 8'h00);
        rd_check("R1 flag cleared", 8'd200, 8'h00);

        // R2: fill every memory word, then read every word back
        for (int i = 0; i < 64; i++) begin
            exp_mem[i] = 8'((i * 37 + 5) & 255);
            cycle(8'(i), exp_mem[i], 1'b1);
        end
        for (int i = 0; i < 64; i++) begin
            rd_check("R2 memory word", 8'(i), exp_mem[i]);
        end

        // R3: write at every register alias, read back at the mirror alias
        for (int a = 64; a < 128; a++) begin
            exp_reg = 8'(a) ^ 8'h5A;
            cycle(8'(a), exp_reg, 1'b1);
            rd_check("R3 register alias", 8'(191 - a), exp_reg);
        end

        // R4 and R8: write at every flag alias, with junk in the upper data bits
        for (int a = 128; a < 256; a++) begin
            exp_flag = a[0] ^ a[1];
            cycle(8'(a), {7'h7F, exp_flag}, 1'b1);
            rd_check("R4/R8 flag alias", 8'(383 - a), {7'b0, exp_flag});
        end

        // R5: no strobe means no change, in every range
        cycle(8'd70, 8'hEE, 1'b0);
        rd_check("R5 register unchanged", 8'd127, exp_reg);
        cycle(8'd130, {7'h00, ~exp_flag}, 1'b0);
        rd_check("R5 flag unchanged", 8'd255, {7'b0, exp_flag});
        cycle(8'd9, ~exp_mem[9], 1'b0);
        rd_check("R5 memory unchanged", 8'd9, exp_mem[9]);

        // R6: each write touches only its own resource
        exp_mem[3] = 8'hC3;
        cycle(8'd3, exp_mem[3], 1'b1);
        rd_check("R6 reg after mem write", 8'd100, exp_reg);
        rd_check("R6 flag after mem write", 8'd140, {7'b0, exp_flag});
        exp_reg = 8'h3C;
        cycle(8'd99, exp_reg, 1'b1);
        rd_check("R6 mem after reg write", 8'd3, exp_mem[3]);
        rd_check("R6 flag after reg write", 8'd141, {7'b0, exp_flag});
        exp_flag = ~exp_flag;
        cycle(8'd222, {7'h00, exp_flag}, 1'b1);
        rd_check("R6 reg after flag write", 8'd64, exp_reg);
        rd_check("R6 mem after flag write", 8'd3, exp_mem[3]);
        rd_check("R6 mem word 2 intact", 8'd2, exp_mem[2]);

        // R9: read during write shows the old content
        cycle(8'd90, 8'h77, 1'b1);
        check("R9 old register value", rd_data, exp_reg);
        exp_reg = 8'h77;
        rd_check("R9 new register value", 8'd90, exp_reg);
        cycle(8'd17, 8'hA1, 1'b1);
        check("R9 old memory value", rd_data, exp_mem[17]);
        exp_mem[17] = 8'hA1;
        rd_check("R9 new memory value", 8'd17, exp_mem[17]);

        // R7: output changes only at the edge after the address changes
        rd_check("R7 register read", 8'd80, exp_reg);
        @(negedge clk);
        addr = 8'd250;
        #2;
        check("R7 holds before edge", rd_data, exp_reg);
        @(posedge clk);
        #1;
        check("R7 follows after edge", rd_data, {7'b0, exp_flag});

        // R1: reset again clears register and flag but not memory
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 rd_data on reset", rd_data, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        rd_check("R1 register cleared again", 8'd65, 8'h00);
        rd_check("R1 flag cleared again", 8'd129, 8'h00);
        rd_check("R1 memory kept", 8'd17, exp_mem[17]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule